// File: doc/BRIEF.md
# External Interrupt Request Detector

This block turns eight maskable interrupt pins and one non-maskable interrupt pin into clean, clocked requests for an interrupt controller. Every pin first passes through a two-flop synchronizer. Each maskable line then detects its event in one of four sense modes: low level, falling edge, rising edge or both edges. When the event is seen, the line sets a status flag. The request output of a line is its flag ANDed with its enable bit. A two-bit priority value per line is held and driven out for a downstream arbiter. The non-maskable pin gives a one-cycle request on the edge chosen by a single polarity bit. It carries a fixed vector number and ignores every enable.

Software reaches the block through a small register port. It writes the sense, enable, priority and polarity registers and reads the status flags. A flag can be cleared in three ways: by software, by an exception-handling acknowledge, or by a data-transfer controller that the line has started. The rules for clearing depend on the sense mode.

Each status flag is a small state machine with three states:
- FL_CLEAR: the flag is 0.
- FL_SET: the flag is 1 and software has not yet seen it.
- FL_ARMED: the flag is 1 and software has read it as 1.

The transitions are:
- CLEAR to SET: on a sense event.
- SET to ARMED: on a read of the status register.
- SET or ARMED to CLEAR: on an acknowledge that qualifies, or, from ARMED only, on a software write of 0.
- ARMED to SET: when a write of 0 meets a new event in the same cycle.

A sense event always wins over a clear that happens in the same cycle.

Top module: `xirq_detect`

## Requirements
- R1: After reset, all sense fields, enable bits, priority fields, status flags and the NMI polarity bit read 0. `irq_req` is 0, and no `nmi_req` pulse occurs while the pins stay high. The register addresses are:
  - 0: sense of lines 3..0, with line n in bits 2n+1:2n.
  - 1: sense of lines 7..4, with line n in bits 2(n-4)+1:2(n-4).
  - 2: enable, with bit n for line n.
  - 3: status, with bit n for line n.
  - 4: priority of lines 3..0, laid out like address 0.
  - 5: priority of lines 7..4, laid out like address 1.
  - 6: NMI polarity in bit 0.
  - Any other address reads 0.
- R2: With sense code 00 (low level), the flag of a line is set in every cycle in which its synchronized pin is low. The flag stays 1 after the pin returns high.
- R3: Sense code 01 sets the flag on a falling edge only. Code 10 sets it on a rising edge only. Code 11 sets it on either edge.
- R4: `irq_req[n]` is the flag of line n ANDed with enable bit n. The status register shows the flag whatever the enable bit is.
- R5: A status write clears flag n only if bit n of the written data is 0 and the flag was read as 1 from address 3 in an earlier bus cycle. A write of 0 without that read leaves the flag set. Writing 1 never changes a flag.
- R6: In low-level mode, an exception acknowledge (`exc_ack` with `exc_line` = n) clears flag n only if the synchronized pin n is high in that cycle.
- R7: In any edge mode, an exception acknowledge for line n clears flag n unconditionally.
- R8: A transfer acknowledge (`xfer_ack` with `xfer_line` = n) clears flag n when `xfer_keep` is 0, and leaves the flag alone when `xfer_keep` is 1.
- R9: If a sense event and any clear condition for a line fall in the same cycle, the flag ends the cycle set.
- R10: The priority registers drive `irq_prio`, with line n in bits 2n+1:2n.
- R11: `nmi_req` pulses high for exactly one cycle for each edge on the NMI pin that matches the polarity bit (0 = falling, 1 = rising). The enable register has no effect on it. `nmi_vector` always reads 7.
- R12: A pin change driven just after a clock edge reaches `irq_req` on the third rising clock edge after that, and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pin | input | 8 | Maskable interrupt pins, idle high |
| nmi_pin | input | 1 | Non-maskable interrupt pin, idle high |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |
| exc_ack | input | 1 | Exception-handling acknowledge strobe |
| exc_line | input | 3 | Line being acknowledged by exception handling |
| xfer_ack | input | 1 | Data-transfer controller start strobe |
| xfer_line | input | 3 | Line that started the transfer |
| xfer_keep | input | 1 | 1 = leave the flag set after the transfer |
| irq_req | output | 8 | Enabled per-line requests |
| irq_prio | output | 16 | Two-bit priority per line |
| nmi_req | output | 1 | One-cycle non-maskable request |
| nmi_vector | output | 8 | Vector number of the non-maskable request |

## Verification
The hardest case to reach from the ports is a sense event and a clear landing in the same clock cycle. The event exists only during the one cycle in which the synchronizer output differs from the previous sample. The stimulus therefore counts exactly two clock edges after it drives a rising edge on a line set to rising mode, and then asserts the exception acknowledge across the third edge. The flag must come out still set. A second hard case is the read-before-write clear rule. The bench writes 0 before any read, then writes 1 after a read, and only then writes 0. It also repeats the read-then-write in level mode while the pin is held low, where the flag must survive.

// File: rtl/xirq_pkg.sv
package xirq_pkg;

    localparam int NUM_LINES = 8;
    localparam int DATA_W    = 8;
    localparam int ADDR_W    = 3;
    localparam int PRIO_W    = 2;
    localparam int LINE_W    = $clog2(NUM_LINES);
    localparam int SENSE_W   = 2;

    typedef enum logic [1:0] {
        SNS_LOW  = 2'b00,
        SNS_FALL = 2'b01,
        SNS_RISE = 2'b10,
        SNS_BOTH = 2'b11
    } sense_e;

    typedef enum logic [1:0] {
        FL_CLEAR = 2'd0,
        FL_SET   = 2'd1,
        FL_ARMED = 2'd2
    } flag_state_e;

    localparam logic [ADDR_W-1:0] A_SENSE_LO = 3'd0;
    localparam logic [ADDR_W-1:0] A_SENSE_HI = 3'd1;
    localparam logic [ADDR_W-1:0] A_ENABLE   = 3'd2;
    localparam logic [ADDR_W-1:0] A_STATUS   = 3'd3;
    localparam logic [ADDR_W-1:0] A_PRIO_LO  = 3'd4;
    localparam logic [ADDR_W-1:0] A_PRIO_HI  = 3'd5;
    localparam logic [ADDR_W-1:0] A_NMI_CTL  = 3'd6;

endpackage

// File: rtl/xirq_sync.sv
module xirq_sync #(
    parameter int              W       = 1,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stage_q[i] <= RST_VAL;
            end
        end else begin
            stage_q[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                stage_q[i] <= stage_q[i-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/xirq_regs.sv
module xirq_regs
    import xirq_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          bus_sel,
    input  logic                          bus_wr,
    input  logic [ADDR_W-1:0]             bus_addr,
    input  logic [DATA_W-1:0]             bus_wdata,
    output logic [DATA_W-1:0]             bus_rdata,
    input  logic [NUM_LINES-1:0]          flags,
    output logic [NUM_LINES*SENSE_W-1:0]  sense,
    output logic [NUM_LINES-1:0]          enable,
    output logic [NUM_LINES*PRIO_W-1:0]   prio,
    output logic                          nmi_rise,
    output logic                          rd_arm,
    output logic [NUM_LINES-1:0]          sw_clr
);

    localparam int HALF = DATA_W;

    logic wr_cyc;
    logic rd_cyc;

    assign wr_cyc = bus_sel &  bus_wr;
    assign rd_cyc = bus_sel & ~bus_wr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sense    <= '0;
            enable   <= '0;
            prio     <= '0;
            nmi_rise <= 1'b0;
        end else if (wr_cyc) begin
            case (bus_addr)
                A_SENSE_LO: sense[HALF-1:0]         <= bus_wdata;
                A_SENSE_HI: sense[2*HALF-1:HALF]    <= bus_wdata;
                A_ENABLE:   enable                  <= bus_wdata;
                A_PRIO_LO:  prio[HALF-1:0]          <= bus_wdata;
                A_PRIO_HI:  prio[2*HALF-1:HALF]     <= bus_wdata;
                A_NMI_CTL:  nmi_rise                <= bus_wdata[0];
                default: ;
            endcase
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (rd_cyc) begin
            case (bus_addr)
                A_SENSE_LO: bus_rdata = sense[HALF-1:0];
                A_SENSE_HI: bus_rdata = sense[2*HALF-1:HALF];
                A_ENABLE:   bus_rdata = enable;
                A_STATUS:   bus_rdata = flags;
                A_PRIO_LO:  bus_rdata = prio[HALF-1:0];
                A_PRIO_HI:  bus_rdata = prio[2*HALF-1:HALF];
                A_NMI_CTL:  bus_rdata = {{(DATA_W-1){1'b0}}, nmi_rise};
                default:    bus_rdata = '0;
            endcase
        end
    end

    assign rd_arm = rd_cyc && (bus_addr == A_STATUS);
    assign sw_clr = (wr_cyc && (bus_addr == A_STATUS)) ? ~bus_wdata : '0;

endmodule

// File: rtl/xirq_line.sv
module xirq_line
    import xirq_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         pin_s,
    input  logic [1:0]   mode,
    input  logic         rd_arm,
    input  logic         sw_clr,
    input  logic         exc_hit,
    input  logic         xfer_hit,
    output logic         flag
);

    flag_state_e state_q;
    flag_state_e state_d;
    logic        prev_q;
    logic        fall;
    logic        rise;
    logic        set_ev;
    logic        ack_clr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= pin_s;
    end

    assign fall = prev_q & ~pin_s;
    assign rise = ~prev_q & pin_s;

    always_comb begin
        unique case (mode)
            SNS_LOW:  set_ev = ~pin_s;
            SNS_FALL: set_ev = fall;
            SNS_RISE: set_ev = rise;
            SNS_BOTH: set_ev = fall | rise;
            default:  set_ev = 1'b0;
        endcase
    end

    assign ack_clr = xfer_hit | (exc_hit & ((mode != SNS_LOW) | pin_s));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FL_CLEAR;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FL_CLEAR: begin
                if (set_ev) state_d = FL_SET;
            end
            FL_SET: begin
                if (ack_clr && !set_ev) state_d = FL_CLEAR;
                else if (rd_arm)        state_d = FL_ARMED;
                else                    state_d = FL_SET;
            end
            FL_ARMED: begin
                if ((ack_clr || sw_clr) && !set_ev) state_d = FL_CLEAR;
                else if (sw_clr)                    state_d = FL_SET;
                else                                state_d = FL_ARMED;
            end
            default: state_d = FL_CLEAR;
        endcase
    end

    // outputs
    always_comb begin
        flag = (state_q != FL_CLEAR);
    end

    AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        set_ev |=> flag); // R3
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_ev && (ack_clr || sw_clr)) |=> flag); // R9
    AST_LEVEL_LOW_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && mode == SNS_LOW && !pin_s) |=> flag); // R6
    AST_NO_BLIND_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FL_SET && !ack_clr) |=> flag); // R5
    AST_FALL_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag) |-> $past(ack_clr || sw_clr)); // R5

endmodule

// File: rtl/xirq_nmi.sv
module xirq_nmi (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_s,
    input  logic rise_sel,
    output logic nmi_req
);

    logic prev_q;
    logic hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= pin_s;
    end

    assign hit = rise_sel ? (~prev_q & pin_s) : (prev_q & ~pin_s);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) nmi_req <= 1'b0;
        else        nmi_req <= hit;
    end

    AST_NMI_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_req |=> !nmi_req); // R11

endmodule

// File: rtl/xirq_detect.sv
module xirq_detect
    import xirq_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int VEC_W       = 8,
    parameter int NMI_VECTOR  = 7
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_LINES-1:0]        irq_pin,
    input  logic                        nmi_pin,
    input  logic                        bus_sel,
    input  logic                        bus_wr,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic [DATA_W-1:0]           bus_wdata,
    output logic [DATA_W-1:0]           bus_rdata,
    input  logic                        exc_ack,
    input  logic [LINE_W-1:0]           exc_line,
    input  logic                        xfer_ack,
    input  logic [LINE_W-1:0]           xfer_line,
    input  logic                        xfer_keep,
    output logic [NUM_LINES-1:0]        irq_req,
    output logic [NUM_LINES*PRIO_W-1:0] irq_prio,
    output logic                        nmi_req,
    output logic [VEC_W-1:0]            nmi_vector
);

    localparam int PIN_W = NUM_LINES + 1;

    logic [PIN_W-1:0]             pins_s;
    logic [NUM_LINES*SENSE_W-1:0] sense;
    logic [NUM_LINES-1:0]         enable;
    logic [NUM_LINES-1:0]         flags;
    logic [NUM_LINES-1:0]         sw_clr;
    logic                         rd_arm;
    logic                         nmi_rise;

    xirq_sync #(
        .W       (PIN_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL ({PIN_W{1'b1}})
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({nmi_pin, irq_pin}),
        .q     (pins_s)
    );

    xirq_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .flags     (flags),
        .sense     (sense),
        .enable    (enable),
        .prio      (irq_prio),
        .nmi_rise  (nmi_rise),
        .rd_arm    (rd_arm),
        .sw_clr    (sw_clr)
    );

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        logic exc_hit;
        logic xfer_hit;

        assign exc_hit  = exc_ack && (exc_line == LINE_W'(g));
        assign xfer_hit = xfer_ack && !xfer_keep && (xfer_line == LINE_W'(g));

        xirq_line u_line (
            .clk      (clk),
            .rst_n    (rst_n),
            .pin_s    (pins_s[g]),
            .mode     (sense[SENSE_W*g +: SENSE_W]),
            .rd_arm   (rd_arm),
            .sw_clr   (sw_clr[g]),
            .exc_hit  (exc_hit),
            .xfer_hit (xfer_hit),
            .flag     (flags[g])
        );
    end

    xirq_nmi u_nmi (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_s    (pins_s[NUM_LINES]),
        .rise_sel (nmi_rise),
        .nmi_req  (nmi_req)
    );

    assign irq_req    = flags & enable;
    assign nmi_vector = VEC_W'(NMI_VECTOR);

endmodule

// File: tb/xirq_detect_bench.sv
module xirq_detect_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  irq_pin = 8'hFF;
    logic        nmi_pin = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [7:0]  bus_wdata = 8'd0;
    logic [7:0]  bus_rdata;
    logic        exc_ack = 1'b0;
    logic [2:0]  exc_line = 3'd0;
    logic        xfer_ack = 1'b0;
    logic [2:0]  xfer_line = 3'd0;
    logic        xfer_keep = 1'b0;
    logic [7:0]  irq_req;
    logic [15:0] irq_prio;
    logic        nmi_req;
    logic [7:0]  nmi_vector;

    xirq_detect u_xirq_detect (
        .clk        (clk),
        .rst_n      (rst_n),
        .irq_pin    (irq_pin),
        .nmi_pin    (nmi_pin),
        .bus_sel    (bus_sel),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .exc_ack    (exc_ack),
        .exc_line   (exc_line),
        .xfer_ack   (xfer_ack),
        .xfer_line  (xfer_line),
        .xfer_keep  (xfer_keep),
        .irq_req    (irq_req),
        .irq_prio   (irq_prio),
        .nmi_req    (nmi_req),
        .nmi_vector (nmi_vector)
    );

    always #10 clk = ~clk;

    typedef struct {
        string       tag;
        int          kind;   // 0 irq_req, 1 bus_rdata, 2 nmi pulse count, 3 irq_prio, 4 nmi_vector
        logic [15:0] exp;
    } exp_t;

    exp_t q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    int   nmi_cnt = 0;
    bit   done = 1'b0;

    // monitor: sample away from the active edge and compare queued items
    always @(negedge clk) begin
        logic [15:0] act;
        exp_t        it;
        if (rst_n && nmi_req) nmi_cnt++;
        while (q.size() > 0) begin
            it = q.pop_front();
            case (it.kind)
                0:       act = {8'h00, irq_req};
                1:       act = {8'h00, bus_rdata};
                2:       act = nmi_cnt[15:0];
                3:       act = irq_prio;
                default: act = {8'h00, nmi_vector};
            endcase
            n_cmp++;
            if (act !== it.exp) begin
                n_bad++;
                $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic wait_n(input int n);
        repeat (n) step();
    endtask

    task automatic push(input string tag, input int kind, input logic [15:0] v);
        exp_t it;
        it.tag  = tag;
        it.kind = kind;
        it.exp  = v;
        q.push_back(it);
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        step();
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input string tag, input logic [2:0] a, input logic [7:0] e);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        push(tag, 1, {8'h00, e});
        step();
        bus_sel = 1'b0;
    endtask

    task automatic exc(input logic [2:0] ln);
        exc_ack = 1'b1; exc_line = ln;
        step();
        exc_ack = 1'b0;
    endtask

    task automatic xfer(input logic [2:0] ln, input logic keep);
        xfer_ack = 1'b1; xfer_line = ln; xfer_keep = keep;
        step();
        xfer_ack = 1'b0; xfer_keep = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog (all requirements): actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        wait_n(3);
        rst_n = 1'b1;
        step();

        // R1 reset state
        push("R1 irq_req", 0, 16'h0000);
        push("R1 irq_prio", 3, 16'h0000);
        push("R1 nmi count", 2, 16'd0);
        push("R11 vector", 4, 16'd7);
        bus_read("R1 sense lo", 3'd0, 8'h00);
        bus_read("R1 enable", 3'd2, 8'h00);
        bus_read("R1 status", 3'd3, 8'h00);
        bus_read("R1 nmi pol", 3'd6, 8'h00);
        bus_read("R1 unused addr", 3'd7, 8'h00);

        bus_write(3'd2, 8'hFF);
        bus_write(3'd0, 8'h01);   // line0 falling

        // R12 latency and R3 falling edge
        irq_pin[0] = 1'b0;
        wait_n(2);
        push("R12 not before third edge", 0, 16'h0000);
        step();
        push("R12 R3 falling sets", 0, 16'h0001);

        // R5 software clear rules
        bus_write(3'd3, 8'h00);
        push("R5 write0 without read", 0, 16'h0001);
        bus_read("R5 status read", 3'd3, 8'h01);
        bus_write(3'd3, 8'h01);
        push("R5 write1 no effect", 0, 16'h0001);
        bus_write(3'd3, 8'hFE);
        push("R5 read then write0 clears", 0, 16'h0000);
        irq_pin[0] = 1'b1;
        wait_n(4);
        push("R3 falling ignores rise", 0, 16'h0000);

        // R3 rising edge on line1, R7 edge ack
        bus_write(3'd0, 8'h09);
        irq_pin[1] = 1'b0;
        wait_n(4);
        push("R3 rising ignores fall", 0, 16'h0000);
        irq_pin[1] = 1'b1;
        wait_n(4);
        push("R3 rising sets", 0, 16'h0002);
        exc(3'd1);
        push("R7 edge ack clears", 0, 16'h0000);

        // R3 both edges on line2
        bus_write(3'd0, 8'h39);
        irq_pin[2] = 1'b0;
        wait_n(4);
        push("R3 both fall", 0, 16'h0004);
        exc(3'd2);
        push("R7 both ack", 0, 16'h0000);
        irq_pin[2] = 1'b1;
        wait_n(4);
        push("R3 both rise", 0, 16'h0004);
        exc(3'd2);
        push("R7 both ack 2", 0, 16'h0000);

        // R2 and R6 level mode on line3
        irq_pin[3] = 1'b0;
        wait_n(4);
        push("R2 level low sets", 0, 16'h0008);
        exc(3'd3);
        push("R6 ack with pin low kept", 0, 16'h0008);
        bus_read("R2 status level", 3'd3, 8'h08);
        bus_write(3'd3, 8'h00);
        push("R9 level sw clear loses", 0, 16'h0008);
        irq_pin[3] = 1'b1;
        wait_n(4);
        push("R2 flag latched", 0, 16'h0008);
        exc(3'd3);
        push("R6 ack with pin high clears", 0, 16'h0000);

        // R4 enable gating
        bus_write(3'd2, 8'h00);
        irq_pin[0] = 1'b0;
        wait_n(4);
        push("R4 masked", 0, 16'h0000);
        bus_read("R4 status while masked", 3'd3, 8'h01);
        bus_write(3'd2, 8'hFF);
        push("R4 enabled", 0, 16'h0001);
        bus_write(3'd2, 8'hFE);
        push("R4 bit0 off", 0, 16'h0000);
        bus_write(3'd2, 8'hFF);
        irq_pin[0] = 1'b1;
        wait_n(4);

        // R8 transfer acknowledge
        xfer(3'd0, 1'b1);
        push("R8 keep set", 0, 16'h0001);
        xfer(3'd0, 1'b0);
        push("R8 clears", 0, 16'h0000);

        // R9 event and ack in the same cycle (line1 rising)
        irq_pin[1] = 1'b0;
        wait_n(4);
        irq_pin[1] = 1'b1;
        wait_n(4);
        push("R9 setup", 0, 16'h0002);
        irq_pin[1] = 1'b0;
        wait_n(4);
        irq_pin[1] = 1'b1;
        wait_n(2);
        exc_ack = 1'b1; exc_line = 3'd1;
        step();
        exc_ack = 1'b0;
        push("R9 set wins over ack", 0, 16'h0002);
        exc(3'd1);
        push("R9 later ack clears", 0, 16'h0000);

        // R10 priority
        bus_write(3'd4, 8'hE4);
        bus_write(3'd5, 8'h1B);
        push("R10 irq_prio", 3, 16'h1BE4);
        bus_read("R10 prio lo", 3'd4, 8'hE4);
        bus_read("R10 prio hi", 3'd5, 8'h1B);

        // R11 non-maskable
        bus_write(3'd2, 8'h00);
        nmi_pin = 1'b0;
        wait_n(5);
        push("R11 falling pulse", 2, 16'd1);
        nmi_pin = 1'b1;
        wait_n(5);
        push("R11 rise ignored", 2, 16'd1);
        bus_write(3'd6, 8'h01);
        bus_read("R11 pol readback", 3'd6, 8'h01);
        nmi_pin = 1'b0;
        wait_n(5);
        push("R11 fall ignored in rise mode", 2, 16'd1);
        nmi_pin = 1'b1;
        wait_n(5);
        push("R11 rising pulse", 2, 16'd2);
        push("R11 vector", 4, 16'd7);
        push("R11 no irq", 0, 16'h0000);

        wait_n(2);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule